// File: doc/BRIEF.md
# Clock source select and divide controller

This block holds one 8-bit control word and uses it to steer a small clock tree. Every clock source is an enable pulse in the single system clock domain: a digitally controlled oscillator (DCO), a second high-frequency oscillator (HF2), and a low-frequency oscillator. The low-frequency oscillator can be fed from a crystal or from an external digital clock. The main tree can take any of the three sources. The subsystem tree takes either the DCO or HF2, and it can be gated off. The auxiliary tree divides the low-frequency pulses by 1, 2, 4 or 8. The HF2 enable output follows the oscillator-off bit, but only while neither tree needs that oscillator.

Software writes the word over a plain strobe-and-data port and reads it back at any time. A change of source is held back to a cycle in which the outgoing source has no pulse. A change of the divide ratio restarts the divider.

Top module: `clk_sel_ctrl`

## Requirements
- R1: After reset the control word reads 0x20 (only bit 5, the HF2-off bit, set), `main_en_o`, `sub_en_o` and `aux_en_o` are 0, and `hf2_osc_en_o` is 0.
- R2: A write with `wr_en_i` high updates the word on that clock edge. `rd_data_o` then returns all 8 bits exactly as written.
- R3: Bits 4:3 select the main source: 00 and 01 select the DCO, 10 selects HF2 and 11 selects the low-frequency source. `main_en_o` is the active source's pulse, delayed by one cycle.
- R4: The active main or subsystem source changes to the requested one only at an edge where the currently active source has no pulse. Until then the old source keeps driving the output.
- R5: Bit 2 selects the subsystem source: 0 selects the DCO and 1 selects HF2. `sub_en_o` is the active source's pulse, delayed by one cycle.
- R6: While bit 6 is 1, `sub_en_o` stays 0 from the edge after the word holds that value.
- R7: Bits 1:0 (code c) set the auxiliary ratio N = 2^c. `aux_en_o` goes high for one cycle on every Nth low-frequency pulse, one cycle after that pulse.
- R8: At the first edge where the divider code differs from the one the divider is using, the count restarts at zero and a low-frequency pulse in that cycle is discarded.
- R9: `hf2_osc_en_o` is 0 only when bit 5 is 1 and HF2 is neither requested nor active for the main or the subsystem tree. Otherwise it is 1.
- R10: With bit 7 set and `lf_hf_mode_i` low, the low-frequency source is `lf_ext_pulse_i`. Otherwise it is `lf_xtal_pulse_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 8 | Control word write data |
| rd_data_o | output | 8 | Control word read data |
| dco_pulse_i | input | 1 | DCO source pulse |
| hf2_pulse_i | input | 1 | Second high-frequency oscillator pulse |
| lf_xtal_pulse_i | input | 1 | Low-frequency crystal pulse |
| lf_ext_pulse_i | input | 1 | Low-frequency external digital clock pulse |
| lf_hf_mode_i | input | 1 | Low-frequency oscillator in high-frequency mode |
| main_en_o | output | 1 | Main clock enable |
| sub_en_o | output | 1 | Subsystem clock enable |
| aux_en_o | output | 1 | Divided auxiliary clock enable |
| hf2_osc_en_o | output | 1 | HF2 oscillator enable |

## Verification
Two events can land in the same cycle: a write that changes the divider code, and a low-frequency pulse that would otherwise advance or complete the count. The bench provokes this by driving the crystal pulse high in the same cycle as the ratio-changing write and in the cycles around it. Random writes with dense pulse traffic also produce it. A behavioural model in the bench states which pulse is discarded and when the next auxiliary pulse falls, and the result is judged against that model on every clock. Held-back source switches that meet a busy outgoing source are judged the same way.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned DIV_CW   = 2;
  localparam int unsigned MAIN_NS  = 3;
  localparam int unsigned SUB_NS   = 2;

  typedef enum logic [1:0] {
    SRC_DCO = 2'd0,
    SRC_HF2 = 2'd1,
    SRC_LF  = 2'd2
  } src_e;

  // field order is the software-visible bit layout, MSB first
  typedef struct packed {
    logic              lf_ext;
    logic              sub_off;
    logic              hf2_off;
    logic [1:0]        main_sel;
    logic              sub_sel;
    logic [DIV_CW-1:0] aux_div;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{lf_ext: 1'b0, sub_off: 1'b0, hf2_off: 1'b1,
                                 main_sel: 2'b00, sub_sel: 1'b0, aux_div: '0};

  function automatic src_e main_src(input logic [1:0] code);
    case (code)
      2'b10:   return SRC_HF2;
      2'b11:   return SRC_LF;
      default: return SRC_DCO;
    endcase
  endfunction
endpackage

// File: rtl/clk_sel_regs.sv
module clk_sel_regs
  import clk_sel_pkg::*;
#(
  parameter ctrl_t RST_VAL = CTRL_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= RST_VAL;
    else if (wr_en_i) ctrl_q <= ctrl_t'(wr_data_i);
  end

  assign ctrl_o    = ctrl_q;
  assign rd_data_o = CTRL_W'(ctrl_q);

  // R2
  wr_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == $past(wr_data_i));
endmodule

// File: rtl/clk_src_mux.sv
module clk_src_mux #(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   req_i,
  input  logic               off_i,
  output logic               en_o,
  output logic [SEL_W-1:0]   act_o
);
  logic [SEL_W-1:0] act_q;
  logic             en_q;
  logic             cur_pulse;

  assign cur_pulse = (32'(act_q) < NUM_SRC) ? src_i[act_q] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= cur_pulse & ~off_i;
      // switch only on an idle cycle of the outgoing source
      if (!cur_pulse) act_q <= req_i;
    end
  end

  assign en_o  = en_q;
  assign act_o = act_q;

  // R4
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_pulse |=> act_q == $past(act_q));
  // R4
  sel_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cur_pulse |=> act_q == $past(req_i));
  // R6
  gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i |=> !en_o);
endmodule

// File: rtl/clk_pow2_div.sv
module clk_pow2_div #(
  parameter int unsigned CODE_W = 2,
  parameter int unsigned MAX_LOG = (1 << CODE_W) - 1,
  parameter int unsigned CNT_W  = (MAX_LOG > 0) ? MAX_LOG : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              en_o
);
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              en_q;
  logic [31:0]       lim_w;
  logic [CNT_W-1:0]  lim;

  assign lim_w = (32'd1 << code_q) - 32'd1;
  assign lim   = lim_w[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
    end else if (code_i != code_q) begin
      code_q <= code_i;
      cnt_q  <= '0;
      en_q   <= 1'b0;
    end else if (src_i) begin
      if (cnt_q == lim) begin
        cnt_q <= '0;
        en_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        en_q  <= 1'b0;
      end
    end else begin
      en_q <= 1'b0;
    end
  end

  assign en_o = en_q;

  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i != code_q) |=> (!en_o && cnt_q == '0));
  // R7
  pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> $past(src_i));
  // R7
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);
endmodule

// File: rtl/clk_sel_ctrl.sv
module clk_sel_ctrl
  import clk_sel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  input  logic              dco_pulse_i,
  input  logic              hf2_pulse_i,
  input  logic              lf_xtal_pulse_i,
  input  logic              lf_ext_pulse_i,
  input  logic              lf_hf_mode_i,
  output logic              main_en_o,
  output logic              sub_en_o,
  output logic              aux_en_o,
  output logic              hf2_osc_en_o
);
  localparam int unsigned MAIN_SW = $clog2(MAIN_NS);
  localparam int unsigned SUB_SW  = $clog2(SUB_NS);

  ctrl_t              ctrl;
  logic               lf_pulse;
  logic [MAIN_NS-1:0] main_src_v;
  logic [SUB_NS-1:0]  sub_src_v;
  logic [MAIN_SW-1:0] main_req, main_act;
  logic [SUB_SW-1:0]  sub_req, sub_act;
  logic               hf2_in_use;

  clk_sel_regs #(.RST_VAL(CTRL_RST)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .ctrl_o    (ctrl)
  );

  // external digital input only in low-frequency mode
  assign lf_pulse = (ctrl.lf_ext && !lf_hf_mode_i) ? lf_ext_pulse_i : lf_xtal_pulse_i;

  assign main_src_v = {lf_pulse, hf2_pulse_i, dco_pulse_i};
  assign sub_src_v  = {hf2_pulse_i, dco_pulse_i};
  assign main_req   = MAIN_SW'(main_src(ctrl.main_sel));
  assign sub_req    = SUB_SW'(ctrl.sub_sel);

  clk_src_mux #(.NUM_SRC(MAIN_NS), .SEL_W(MAIN_SW)) u_main_mux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (main_src_v),
    .req_i  (main_req),
    .off_i  (1'b0),
    .en_o   (main_en_o),
    .act_o  (main_act)
  );

  clk_src_mux #(.NUM_SRC(SUB_NS), .SEL_W(SUB_SW)) u_sub_mux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (sub_src_v),
    .req_i  (sub_req),
    .off_i  (ctrl.sub_off),
    .en_o   (sub_en_o),
    .act_o  (sub_act)
  );

  clk_pow2_div #(.CODE_W(DIV_CW)) u_aux_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (lf_pulse),
    .code_i (ctrl.aux_div),
    .en_o   (aux_en_o)
  );

  assign hf2_in_use = (main_req == MAIN_SW'(SRC_HF2)) || (main_act == MAIN_SW'(SRC_HF2)) ||
                      (sub_req  == SUB_SW'(SRC_HF2))  || (sub_act  == SUB_SW'(SRC_HF2));
  assign hf2_osc_en_o = !ctrl.hf2_off || hf2_in_use;

  // R9
  hf2_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[5] |-> hf2_osc_en_o);
  // R9
  hf2_used_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_act == MAIN_SW'(SRC_HF2) || sub_act == SUB_SW'(SRC_HF2)) |-> hf2_osc_en_o);
  // R3
  main_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_en_o |-> $past(dco_pulse_i || hf2_pulse_i || lf_pulse));
endmodule

// File: tb/clk_sel_ctrl_tb.sv
`timescale 1ns/1ps
module clk_sel_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       dco_pulse_i = 1'b0, hf2_pulse_i = 1'b0;
  logic       lf_xtal_pulse_i = 1'b0, lf_ext_pulse_i = 1'b0, lf_hf_mode_i = 1'b0;
  logic       main_en_o, sub_en_o, aux_en_o, hf2_osc_en_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  clk_sel_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .dco_pulse_i(dco_pulse_i), .hf2_pulse_i(hf2_pulse_i),
    .lf_xtal_pulse_i(lf_xtal_pulse_i), .lf_ext_pulse_i(lf_ext_pulse_i),
    .lf_hf_mode_i(lf_hf_mode_i), .main_en_o(main_en_o), .sub_en_o(sub_en_o),
    .aux_en_o(aux_en_o), .hf2_osc_en_o(hf2_osc_en_o)
  );

  // behavioural reference model
  logic [7:0] m_reg;
  int         m_main_act, m_sub_act, m_cnt, m_code;
  bit         m_main_en, m_sub_en, m_aux_en;
  bit         m_lf;
  bit [2:0]   m_src3;
  int         m_main_req, m_sub_req;

  always_comb begin
    m_lf   = (m_reg[7] && !lf_hf_mode_i) ? lf_ext_pulse_i : lf_xtal_pulse_i; // R10
    m_src3 = {m_lf, hf2_pulse_i, dco_pulse_i};
    case (m_reg[4:3])                                                        // R3
      2'b10:   m_main_req = 1;
      2'b11:   m_main_req = 2;
      default: m_main_req = 0;
    endcase
    m_sub_req = m_reg[2] ? 1 : 0;                                            // R5
  end

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_reg <= 8'h20; m_main_act <= 0; m_sub_act <= 0; m_cnt <= 0; m_code <= 0;
      m_main_en <= 0; m_sub_en <= 0; m_aux_en <= 0;
    end else begin
      if (wr_en_i) m_reg <= wr_data_i;
      m_main_en <= m_src3[m_main_act];
      if (!m_src3[m_main_act]) m_main_act <= m_main_req;
      m_sub_en <= !m_reg[6] && m_src3[m_sub_act];
      if (!m_src3[m_sub_act]) m_sub_act <= m_sub_req;
      if (int'(m_reg[1:0]) != m_code) begin
        m_code <= int'(m_reg[1:0]); m_cnt <= 0; m_aux_en <= 0;
      end else if (m_lf) begin
        if (m_cnt == (1 << m_code) - 1) begin m_cnt <= 0; m_aux_en <= 1; end
        else begin m_cnt <= m_cnt + 1; m_aux_en <= 0; end
      end else m_aux_en <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit exp_hf2;
    exp_hf2 = !(m_reg[5] && !(m_main_req == 1 || m_main_act == 1 || m_sub_req == 1 || m_sub_act == 1));
    chk(rd_data_o == m_reg, "R2 read data", rd_data_o, m_reg);
    chk(main_en_o == m_main_en, "R3/R4/R10 main_en", 8'(main_en_o), 8'(m_main_en));
    chk(sub_en_o == m_sub_en, "R5/R6 sub_en", 8'(sub_en_o), 8'(m_sub_en));
    chk(aux_en_o == m_aux_en, "R7/R8 aux_en", 8'(aux_en_o), 8'(m_aux_en));
    chk(hf2_osc_en_o == exp_hf2, "R9 hf2_osc_en", 8'(hf2_osc_en_o), 8'(exp_hf2));
  endtask

  // one cycle: check outputs, then drive next inputs
  task automatic step(input bit wr, input logic [7:0] val, input int dens, input bit force_lf);
    @(negedge clk_i);
    compare_all();
    wr_en_i         = wr;
    wr_data_i       = val;
    dco_pulse_i     = ($urandom_range(99) < dens);
    hf2_pulse_i     = ($urandom_range(99) < dens);
    lf_xtal_pulse_i = force_lf | ($urandom_range(99) < dens);
    lf_ext_pulse_i  = ($urandom_range(99) < dens);
  endtask

  task automatic write_run(input logic [7:0] val, input int cycles, input int dens);
    step(1'b1, val, dens, 1'b0);
    for (int i = 0; i < cycles; i++) step(1'b0, 8'h00, dens, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(rd_data_o == 8'h20, "R1 reset word", rd_data_o, 8'h20);
    chk({main_en_o, sub_en_o, aux_en_o} == 3'b000, "R1 reset enables",
        8'({main_en_o, sub_en_o, aux_en_o}), 8'h00);
    chk(hf2_osc_en_o == 1'b0, "R1 reset hf2 enable", 8'(hf2_osc_en_o), 8'h00);
    rst_ni = 1'b1;
    for (int i = 0; i < 20; i++) step(1'b0, 8'h00, 50, 1'b0);
    write_run(8'h00, 40, 50);   // R9 off bit cleared
    write_run(8'h18, 60, 50);   // R3 main from LF
    write_run(8'h10, 40, 70);   // R3/R4 main from HF2, busy old source
    write_run(8'h30, 30, 50);   // R9 off requested but HF2 in use
    write_run(8'h08, 30, 90);   // R3 code 01 selects DCO
    write_run(8'h24, 30, 50);   // R5/R9 sub from HF2
    write_run(8'h20, 30, 50);   // R9 off honoured once unused
    write_run(8'h44, 30, 60);   // R6 sub gated off
    write_run(8'h01, 80, 60);   // R7 /2
    write_run(8'h02, 80, 60);   // R7 /4
    write_run(8'h03, 100, 60);  // R7 /8
    // R8 ratio change in a cycle carrying an LF pulse
    step(1'b1, 8'h02, 0, 1'b1);
    step(1'b0, 8'h00, 0, 1'b1);
    step(1'b0, 8'h00, 0, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b0, 8'h00, 60, 1'b0);
    step(1'b1, 8'h01, 60, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b0, 8'h00, 60, 1'b0);
    // R10 external digital LF input
    write_run(8'h98, 60, 40);
    lf_hf_mode_i = 1'b1;
    for (int i = 0; i < 60; i++) step(1'b0, 8'h00, 40, 1'b0);
    lf_hf_mode_i = 1'b0;
    // random mix of writes and traffic
    for (int i = 0; i < 3000; i++)
      step(($urandom_range(9) == 0), 8'($urandom), $urandom_range(90), 1'b0);
    step(1'b0, 8'h00, 0, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule